// File: doc/BRIEF.md
# Converter Sample Buffer with Deferred-Load Conversion Counter

This block sits between an analog-to-digital converter and a host register port. Each completed conversion arrives as a single-cycle strobe carrying a 12-bit result and a 4-bit channel tag. The block packs the result and the tag into one 16-bit word and queues the word in a first-in first-out store that holds 1024 entries. The host drains the store by reading the data offset. Each read returns the oldest word one cycle after the read strobe.

A 16-bit down counter steps once per conversion. Software loads it through a pending register, and the pending value only enters the counter on the next conversion, not on the write. Software can therefore work out how many words are waiting from the counter value and its own running total of words read. A status offset shows two flags. The data-ready flag also drives the interrupt line and is cleared by a write to its own offset. The overrun flag is sticky. A write to the data offset sends a one-cycle pulse out to the converter to start a software conversion.

Top module: `smp_fifo_ctr`

## Requirements
- R1: While reset is held and after it is released, the data-ready flag, the overrun flag, `irq`, `sw_conv`, the stored word count, the counter and `host_rdata` are all zero.
- R2: Each conversion stores the word {result in bits 15:4, channel tag in bits 3:0}. A host read at offset 0 (0x0) returns the stored words in arrival order, and each value appears on `host_rdata` on the clock after the read strobe.
- R3: The store holds 1024 words. A conversion that arrives while the store is full, with no pop in the same cycle, is dropped and sets the overrun flag at status bit 5 (0x20).
- R4: The overrun flag stays set while `acq_en` is high and clears on the clock after `acq_en` is low. Overrun never drives `irq` by itself.
- R5: Every conversion sets the data-ready flag (status bit 7, 0x80, mirrored on `irq`). The flag stays set until any write to offset 4 (0x4). When a conversion and that write fall in the same cycle, the flag ends up set.
- R6: Any write to offset 0 produces a `sw_conv` pulse exactly one cycle long, on the clock after the write.
- R7: The counter is read at offset 8 (0x8). Each conversion that finds no load pending decrements it by one, and it wraps from 0x0000 to 0xFFFF.
- R8: A write to offset 8 leaves the counter unchanged. The next conversion loads the written value without decrementing, and later conversions decrement from that value.
- R9: A read at offset 0 while the store is empty returns the last word read before it and does not move the read position. The next conversion's word is then the next one returned.
- R10: A read at offset 2 (0x2) returns the status word, with every bit other than 7 and 5 at zero. A read at any unmapped offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_en | input | 1 | Acquisition enable; low clears the overrun flag |
| conv_done | input | 1 | One-cycle strobe for a completed conversion |
| conv_result | input | 12 | Conversion result |
| conv_chan | input | 4 | Channel tag of the conversion |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 4 | Host register offset |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Registered host read data |
| irq | output | 1 | Interrupt, equal to the data-ready flag |
| sw_conv | output | 1 | One-cycle software conversion start pulse |

## Verification
The hardest state to reach from the ports is a store that is completely full. Only there does the overrun flag set, and only there does the last-written slot sit next to the read position. The stimulus pushes exactly 1024 conversions, each with a result and tag derived from its index, and then sends one more. It then drains all 1024 words and checks that the extra word never appears. After that it reads once more on the empty store, where the last word must repeat. It also clears data-ready while the overrun flag is still set, to show that overrun alone leaves `irq` low.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
    // Register offsets; software depends on these values.
    localparam int OFS_DATA = 0;
    localparam int OFS_STAT = 2;
    localparam int OFS_CLR  = 4;
    localparam int OFS_CNT  = 8;
    // Status bit positions.
    localparam int ST_DRDY_BIT = 7;
    localparam int ST_OVR_BIT  = 5;
endpackage

// File: rtl/sfc_store.sv
module sfc_store #(
    parameter int DEPTH = 1024,
    parameter int W     = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_data;
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/sfc_ctl.sv
module sfc_ctl #(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acq_en,
    input  logic          push_req,
    input  logic          pop_req,
    output logic          push_ok,
    output logic          pop_ok,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] rptr,
    output logic [LW-1:0] level,
    output logic          ovr
);
    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [LW-1:0] level;
        logic          ovr;
    } ctl_t;

    ctl_t s_d, s_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        pop_ok  = pop_req && (s_q.level != '0);
        push_ok = push_req && ((s_q.level != LW'(DEPTH)) || pop_ok);
        s_d     = s_q;
        if (push_ok) s_d.wptr = bump(s_q.wptr);
        if (pop_ok)  s_d.rptr = bump(s_q.rptr);
        if (push_ok && !pop_ok)      s_d.level = s_q.level + 1'b1;
        else if (!push_ok && pop_ok) s_d.level = s_q.level - 1'b1;
        if (!acq_en)                  s_d.ovr = 1'b0;
        else if (push_req && !push_ok) s_d.ovr = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wptr  = s_q.wptr;
    assign rptr  = s_q.rptr;
    assign level = s_q.level;
    assign ovr   = s_q.ovr;
endmodule

// File: rtl/sfc_cnt.sv
module sfc_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         ld_we,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt,
    output logic         pend
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] pval;
        logic         pend;
    } cnt_t;

    cnt_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (tick) begin
            if (s_q.pend) begin
                s_d.cnt  = s_q.pval;
                s_d.pend = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
        if (ld_we) begin
            s_d.pend = 1'b1;
            s_d.pval = ld_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt  = s_q.cnt;
    assign pend = s_q.pend;
endmodule

// File: rtl/smp_fifo_ctr.sv
module smp_fifo_ctr
    import sfc_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int RES_W  = 12,
    parameter int TAG_W  = 4,
    parameter int ADDR_W = 4,
    localparam int HW    = RES_W + TAG_W,
    localparam int AW    = $clog2(DEPTH),
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acq_en,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_result,
    input  logic [TAG_W-1:0]  conv_chan,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [HW-1:0]     host_wdata,
    output logic [HW-1:0]     host_rdata,
    output logic              irq,
    output logic              sw_conv
);
    typedef struct packed {
        logic          drdy;
        logic          swc;
        logic [HW-1:0] rdata;
        logic [HW-1:0] last;
    } top_t;

    top_t s_d, s_q;

    logic          fifo_push_ok, fifo_pop_ok, fifo_ovr;
    logic [AW-1:0] fifo_wptr, fifo_rptr;
    logic [LW-1:0] fifo_level;
    logic [HW-1:0] head_word, status_word;
    logic [HW-1:0] cnt_val;
    logic          cnt_pend;

    logic hit_data, hit_stat, hit_clr, hit_cnt;
    assign hit_data = host_addr == ADDR_W'(OFS_DATA);
    assign hit_stat = host_addr == ADDR_W'(OFS_STAT);
    assign hit_clr  = host_addr == ADDR_W'(OFS_CLR);
    assign hit_cnt  = host_addr == ADDR_W'(OFS_CNT);

    sfc_ctl #(.DEPTH(DEPTH)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .acq_en   (acq_en),
        .push_req (conv_done),
        .pop_req  (host_rd && hit_data),
        .push_ok  (fifo_push_ok),
        .pop_ok   (fifo_pop_ok),
        .wptr     (fifo_wptr),
        .rptr     (fifo_rptr),
        .level    (fifo_level),
        .ovr      (fifo_ovr)
    );

    sfc_store #(.DEPTH(DEPTH), .W(HW)) u_store (
        .clk     (clk),
        .wr_en   (fifo_push_ok),
        .wr_addr (fifo_wptr),
        .wr_data ({conv_result, conv_chan}),
        .rd_addr (fifo_rptr),
        .rd_data (head_word)
    );

    sfc_cnt #(.W(HW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (conv_done),
        .ld_we  (host_wr && hit_cnt),
        .ld_val (host_wdata),
        .cnt    (cnt_val),
        .pend   (cnt_pend)
    );

    always_comb begin
        status_word              = '0;
        status_word[ST_DRDY_BIT] = s_q.drdy;
        status_word[ST_OVR_BIT]  = fifo_ovr;

        s_d     = s_q;
        s_d.swc = host_wr && hit_data;
        if (host_wr && hit_clr) s_d.drdy = 1'b0;
        if (conv_done)          s_d.drdy = 1'b1;
        if (host_rd) begin
            if (hit_data) begin
                if (fifo_pop_ok) begin
                    s_d.rdata = head_word;
                    s_d.last  = head_word;
                end else begin
                    s_d.rdata = s_q.last;
                end
            end else if (hit_stat) begin
                s_d.rdata = status_word;
            end else if (hit_cnt) begin
                s_d.rdata = cnt_val;
            end else begin
                s_d.rdata = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign host_rdata = s_q.rdata;
    assign irq        = s_q.drdy;
    assign sw_conv    = s_q.swc;
endmodule

// File: rtl/sfc_chk.sv
module sfc_chk #(
    parameter int DEPTH  = 1024,
    parameter int ADDR_W = 4,
    parameter int HW     = 16,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acq_en,
    input logic              conv_done,
    input logic              host_wr,
    input logic              host_rd,
    input logic [ADDR_W-1:0] host_addr,
    input logic              irq,
    input logic              sw_conv,
    input logic [LW-1:0]     level,
    input logic              pop_ok,
    input logic              ovr,
    input logic [HW-1:0]     cnt,
    input logic              pend
);
    assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));

    assert_drop_sets_ovr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done && acq_en && level == LW'(DEPTH) && !pop_ok |=> ovr);

    assert_ovr_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !acq_en |=> !ovr);

    assert_ovr_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ovr && acq_en |=> ovr);

    assert_drdy_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> irq);

    assert_sw_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && host_addr == ADDR_W'(0) |=> sw_conv);

    assert_cnt_dec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done && !pend |=> cnt == HW'($past(cnt) - 1'b1));

    assert_cnt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done |=> $stable(cnt));

    assert_load_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && host_addr == ADDR_W'(8) |=> pend);

    assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && host_addr == ADDR_W'(0) && level == '0 && !conv_done |=> level == '0);
endmodule

bind smp_fifo_ctr sfc_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .HW(HW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acq_en    (acq_en),
    .conv_done (conv_done),
    .host_wr   (host_wr),
    .host_rd   (host_rd),
    .host_addr (host_addr),
    .irq       (irq),
    .sw_conv   (sw_conv),
    .level     (fifo_level),
    .pop_ok    (fifo_pop_ok),
    .ovr       (fifo_ovr),
    .cnt       (cnt_val),
    .pend      (cnt_pend)
);

// File: tb/sim_smp_fifo_ctr.sv
module sim_smp_fifo_ctr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acq_en = 1'b1;
    logic        conv_done = 1'b0;
    logic [11:0] conv_result = '0;
    logic [3:0]  conv_chan = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        irq;
    logic        sw_conv;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    smp_fifo_ctr u0 (
        .clk(clk), .rst_n(rst_n), .acq_en(acq_en), .conv_done(conv_done),
        .conv_result(conv_result), .conv_chan(conv_chan), .host_wr(host_wr),
        .host_rd(host_rd), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .irq(irq), .sw_conv(sw_conv)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        acq_en = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_conv(input logic [11:0] res, input logic [3:0] tag);
        @(negedge clk);
        conv_done = 1'b1; conv_result = res; conv_chan = tag;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    task automatic do_write(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic do_read(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic t_reset_state();
        logic [15:0] v;
        do_reset();
        chk("R1 irq", {15'd0, irq}, 16'd0);
        chk("R1 sw_conv", {15'd0, sw_conv}, 16'd0);
        chk("R1 rdata", host_rdata, 16'd0);
        do_read(4'h2, v); chk("R1 status", v, 16'h0000);
        do_read(4'h8, v); chk("R1 counter", v, 16'h0000);
        do_read(4'h0, v); chk("R1 empty data", v, 16'h0000);
    endtask

    task automatic t_order();
        logic [15:0] v;
        do_reset();
        do_conv(12'hABC, 4'h5);
        do_conv(12'h123, 4'hE);
        do_conv(12'hFFF, 4'h0);
        do_read(4'h0, v); chk("R2 word0 layout", v, 16'hABC5);
        do_read(4'h0, v); chk("R2 word1", v, 16'h123E);
        do_read(4'h0, v); chk("R2 word2", v, 16'hFFF0);
        do_read(4'h2, v); chk("R10 status drdy only", v, 16'h0080);
        do_read(4'h6, v); chk("R10 unmapped read", v, 16'h0000);
    endtask

    task automatic t_empty_read();
        logic [15:0] v;
        do_reset();
        do_conv(12'h456, 4'h7);
        do_read(4'h0, v); chk("R9 first word", v, 16'h4567);
        do_read(4'h0, v); chk("R9 empty repeats last", v, 16'h4567);
        do_read(4'h0, v); chk("R9 empty repeats again", v, 16'h4567);
        do_conv(12'h89A, 4'h2);
        do_read(4'h0, v); chk("R9 pointer not moved", v, 16'h89A2);
    endtask

    task automatic t_overrun();
        logic [15:0] v;
        int bad;
        do_reset();
        for (int i = 0; i < 1024; i++) do_conv(12'(i), 4'(i));
        do_read(4'h2, v); chk("R3 full no overrun", v, 16'h0080);
        do_conv(12'hABC, 4'hD);
        do_read(4'h2, v); chk("R3 overrun status", v, 16'h00A0);
        bad = 0;
        for (int i = 0; i < 1024; i++) begin
            do_read(4'h0, v);
            if (v !== {12'(i), 4'(i)}) bad++;
        end
        chk("R3 all 1024 kept in order", 16'(bad), 16'd0);
        chk("R3 last stored word", v, 16'h3FFF);
        do_read(4'h0, v); chk("R3 dropped word absent", v, 16'h3FFF);
        do_read(4'h2, v); chk("R4 overrun sticky", v, 16'h00A0);
        do_write(4'h4, 16'h0000);
        chk("R4 overrun no irq", {15'd0, irq}, 16'd0);
        do_read(4'h2, v); chk("R4 status after clear", v, 16'h0020);
        @(negedge clk); acq_en = 1'b0;
        @(negedge clk); acq_en = 1'b1;
        do_read(4'h2, v); chk("R4 overrun cleared by disable", v, 16'h0000);
    endtask

    task automatic t_drdy();
        logic [15:0] v;
        do_reset();
        do_conv(12'h001, 4'h1);
        chk("R5 irq set", {15'd0, irq}, 16'd1);
        repeat (3) @(negedge clk);
        chk("R5 irq holds", {15'd0, irq}, 16'd1);
        do_write(4'h4, 16'h1234);
        chk("R5 irq cleared", {15'd0, irq}, 16'd0);
        @(negedge clk);
        conv_done = 1'b1; host_wr = 1'b1; host_addr = 4'h4;
        @(negedge clk);
        conv_done = 1'b0; host_wr = 1'b0;
        chk("R5 set wins over clear", {15'd0, irq}, 16'd1);
        do_read(4'h2, v); chk("R5 status drdy", v, 16'h0080);
    endtask

    task automatic t_swconv();
        do_reset();
        do_write(4'h0, 16'hFFFF);
        chk("R6 pulse high", {15'd0, sw_conv}, 16'd1);
        @(negedge clk);
        chk("R6 pulse one cycle", {15'd0, sw_conv}, 16'd0);
        do_write(4'h4, 16'h0000);
        chk("R6 no pulse other offset", {15'd0, sw_conv}, 16'd0);
    endtask

    task automatic t_counter();
        logic [15:0] v;
        do_reset();
        do_conv(12'h0, 4'h0);
        do_read(4'h8, v); chk("R7 wrap to FFFF", v, 16'hFFFF);
        do_conv(12'h0, 4'h0);
        do_read(4'h8, v); chk("R7 decrement", v, 16'hFFFE);
        do_write(4'h8, 16'h0005);
        do_read(4'h8, v); chk("R8 load deferred", v, 16'hFFFE);
        do_conv(12'h0, 4'h0);
        do_read(4'h8, v); chk("R8 loaded on conversion", v, 16'h0005);
        do_conv(12'h0, 4'h0);
        do_read(4'h8, v); chk("R8 decrement after load", v, 16'h0004);
    endtask

    initial begin
        t_reset_state();
        t_order();
        t_empty_read();
        t_drdy();
        t_swconv();
        t_counter();
        t_overrun();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule